// File: doc/BRIEF.md
# Two-Stage Fallback Watchdog

This block guards a clock-frequency change. Software arms it before switching to a new frequency and must disarm it within a programmed time span. If the span runs out while the watchdog is armed, the block drives an active-low reset pulse of fixed length. It also moves its frequency-source select to a safer setting for the restart. The first timeout picks either the programmed fall-back frequency or the hardware jumper frequency, depending on a mode bit. A further timeout while on the fall-back frequency picks the jumper frequency.

Time is counted in ticks from an external prescaled timebase. The span is a 6-bit count of units. A 2-bit unit code scales each unit by a power of two in ticks. The span and unit are sampled only while the watchdog is disarmed. A sticky status bit records that a watchdog reset has happened. A one-cycle strobe, gated by a control input, tells the neighbouring frequency logic to reload its fine-step register with its initial value.

Top module: `wdog_fallback`

## Requirements
- R1: After reset, `wd_rst_no` is 1, `src_o` is 0 (programmed source), `wd_fired_o` is 0 and `lp_reload_o` is 0.
- R2: While `wd_en_i` stays 1, `wd_rst_no` falls in the cycle after the edge that counts the L-th tick. L = max(span,1) << (unit × UNIT_STEP_LOG2) ticks.
- R3: A span value of 0 behaves as a span of 1 unit.
- R4: Once low, `wd_rst_no` stays low for exactly PULSE_TICKS ticks and then returns to 1. A timeout cannot restart a pulse that is already running. The span counter is held at 0 during the pulse and counts again afterwards.
- R5: Clearing `wd_en_i` before the span runs out prevents any pulse and clears the tick count. A later arm waits a full span.
- R6: Span and unit are sampled on every edge at which `wd_en_i` is 0. Changes made while armed have no effect on the running span.
- R7: On the first timeout after arming, `src_o` becomes 1 (fall-back) if `fb_mode_i` is 1, or 2 (jumper) if it is 0. It changes in the same cycle that `wd_rst_no` falls.
- R8: A timeout while `src_o` is 1 moves it to 2. A timeout while `src_o` is 2 keeps it at 2.
- R9: On any edge at which `wd_en_i` is 0, the escalation is cleared and `src_o` returns to 0, so the next arm starts a fresh first stage.
- R10: `wd_fired_o` is set in the cycle of the first pulse and stays 1 until reset.
- R11: `lp_reload_o` is high for exactly the one cycle in which `wd_rst_no` falls, and only if `lp_reinit_i` was 1 at the timeout. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase tick |
| wd_en_i | input | 1 | Arm (1) / disarm (0) |
| span_i | input | IVL_W | Span in units |
| unit_i | input | UNIT_W | Unit code, scale 2^(code×UNIT_STEP_LOG2) ticks |
| fb_mode_i | input | 1 | First-stage source: 1 fall-back, 0 jumper |
| lp_reinit_i | input | 1 | Request fine-step register reload on timeout |
| wd_rst_no | output | 1 | Active-low watchdog reset pulse |
| src_o | output | 2 | Frequency source: 0 programmed, 1 fall-back, 2 jumper |
| wd_fired_o | output | 1 | Sticky watchdog-reset-occurred status |
| lp_reload_o | output | 1 | One-cycle reload strobe |

## Verification
The assertions check several rules on every cycle:
- the sampled limit stays frozen while the watchdog is armed;
- the counter is clear while disarmed;
- the pulse cannot end without a tick;
- the source select changes only on a timeout or a disarm, and never leaves the jumper setting while armed;
- the status bit is sticky, and the reload strobe coincides with the falling pulse.

Only the bench scenarios can show the exact span length for each span and unit value, the zero-span rule, and the exact pulse width in ticks. The same holds for the order of escalation over repeated timeouts and the fresh first stage after a disarm. A behavioural model compared on every clock covers these under both continuous and sparse ticks.

// File: rtl/wdog_fb_pkg.sv
package wdog_fb_pkg;
   typedef enum logic [1:0] {
      SRC_PROG     = 2'd0,
      SRC_FALLBACK = 2'd1,
      SRC_JUMPER   = 2'd2
   } wd_src_e;

   // widest limit: full span scaled by the largest unit code
   function automatic int limit_width(input int ivl_w, input int unit_w, input int step_log2);
      return ivl_w + ((1 << unit_w) - 1) * step_log2;
   endfunction
endpackage

// File: rtl/wdog_cfg_hold.sv
module wdog_cfg_hold #(
   parameter int IVL_W          = 6,
   parameter int UNIT_W         = 2,
   parameter int UNIT_STEP_LOG2 = 1,
   parameter int CNT_W          = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [IVL_W-1:0]  span_i,
   input  logic [UNIT_W-1:0] unit_i,
   output logic [CNT_W-1:0]  limit_o
);
   logic [CNT_W-1:0] units_eff;
   logic [CNT_W-1:0] limit_d;
   logic [CNT_W-1:0] limit_q;

   initial begin
      assert (CNT_W >= IVL_W) else $error("limit width below span width");
   end

   // zero span is treated as one unit
   always_comb units_eff = (span_i == '0) ? CNT_W'(1) : CNT_W'(span_i);

   generate
      if (UNIT_STEP_LOG2 == 0) begin : g_flat_unit
         always_comb limit_d = units_eff;
      end else begin : g_scaled_unit
         always_comb limit_d = units_eff << (32'(unit_i) * UNIT_STEP_LOG2);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     limit_q <= CNT_W'(1);
      else if (!en_i) limit_q <= limit_d;
   end

   assign limit_o = limit_q;

   // R6
   limit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> $stable(limit_q));

   // R3
   limit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      limit_q != '0);
endmodule

// File: rtl/wdog_span_cnt.sv
module wdog_span_cnt #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             busy_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             last_tick;

   always_comb last_tick = (cnt_q == limit_i - CNT_W'(1));
   always_comb expire_o  = en_i & ~busy_i & tick_i & last_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (!en_i || busy_i || expire_o)   cnt_q <= '0;
      else if (tick_i)                        cnt_q <= cnt_q + CNT_W'(1);
   end

   // R5
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> cnt_q == '0);

   // R4
   hold_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> cnt_q == '0);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int PULSE_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic expire_i,
   output logic busy_o
);
   logic busy_q;

   initial begin
      assert (PULSE_TICKS >= 1) else $error("pulse must last at least one tick");
   end

   generate
      if (PULSE_TICKS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        busy_q <= 1'b0;
            else if (expire_i) busy_q <= 1'b1;
            else if (tick_i)   busy_q <= 1'b0;
         end
      end else begin : g_multi
         localparam int PW = $clog2(PULSE_TICKS + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               left_q <= '0;
            end else if (expire_i && !busy_q) begin
               busy_q <= 1'b1;
               left_q <= PW'(PULSE_TICKS);
            end else if (busy_q && tick_i) begin
               left_q <= left_q - PW'(1);
               if (left_q == PW'(1)) busy_q <= 1'b0;
            end
         end
      end
   endgenerate

   assign busy_o = busy_q;

   // R4
   no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !expire_i);
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
   import wdog_fb_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en_i,
   input  logic    expire_i,
   input  logic    fb_mode_i,
   input  logic    lp_sel_i,
   output wd_src_e src_o,
   output logic    fired_o,
   output logic    lp_o
);
   wd_src_e src_q, src_d;
   logic    fired_q, lp_q;

   always_comb begin
      src_d = src_q;
      if (!en_i) begin
         src_d = SRC_PROG;
      end else if (expire_i) begin
         unique case (src_q)
            SRC_PROG:     src_d = fb_mode_i ? SRC_FALLBACK : SRC_JUMPER;
            SRC_FALLBACK: src_d = SRC_JUMPER;
            default:      src_d = SRC_JUMPER;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= SRC_PROG;
         fired_q <= 1'b0;
         lp_q    <= 1'b0;
      end else begin
         src_q   <= src_d;
         fired_q <= fired_q | expire_i;
         lp_q    <= expire_i & lp_sel_i;
      end
   end

   assign src_o   = src_q;
   assign fired_o = fired_q;
   assign lp_o    = lp_q;

   // R7
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !expire_i) |=> $stable(src_q));

   // R9
   src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> src_q == SRC_PROG);

   // R8
   jumper_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && src_q == SRC_JUMPER) |=> src_q == SRC_JUMPER);

   // R10
   fired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fired_q |=> fired_q);
endmodule

// File: rtl/wdog_fallback.sv
module wdog_fallback
   import wdog_fb_pkg::*;
#(
   parameter int IVL_W          = 6,
   parameter int UNIT_W         = 2,
   parameter int UNIT_STEP_LOG2 = 1,
   parameter int PULSE_TICKS    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wd_en_i,
   input  logic [IVL_W-1:0]  span_i,
   input  logic [UNIT_W-1:0] unit_i,
   input  logic              fb_mode_i,
   input  logic              lp_reinit_i,
   output logic              wd_rst_no,
   output logic [1:0]        src_o,
   output logic              wd_fired_o,
   output logic              lp_reload_o
);
   localparam int CNT_W = limit_width(IVL_W, UNIT_W, UNIT_STEP_LOG2);

   logic [CNT_W-1:0] limit;
   logic             expire;
   logic             busy;
   wd_src_e          src;

   initial begin
      assert (IVL_W >= 1 && UNIT_W >= 1) else $error("span and unit widths must be positive");
      assert (UNIT_STEP_LOG2 >= 0) else $error("unit step must be non-negative");
   end

   wdog_cfg_hold #(
      .IVL_W(IVL_W), .UNIT_W(UNIT_W), .UNIT_STEP_LOG2(UNIT_STEP_LOG2), .CNT_W(CNT_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .en_i(wd_en_i),
      .span_i(span_i), .unit_i(unit_i), .limit_o(limit)
   );

   wdog_span_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en_i(wd_en_i), .tick_i(tick_i),
      .busy_i(busy), .limit_i(limit), .expire_o(expire)
   );

   wdog_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .expire_i(expire), .busy_o(busy)
   );

   wdog_escalate u_esc (
      .clk(clk), .rst_n(rst_n), .en_i(wd_en_i), .expire_i(expire),
      .fb_mode_i(fb_mode_i), .lp_sel_i(lp_reinit_i),
      .src_o(src), .fired_o(wd_fired_o), .lp_o(lp_reload_o)
   );

   assign wd_rst_no = ~busy;
   assign src_o     = src;

   // R4
   pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_rst_no && !tick_i) |=> !wd_rst_no);

   // R11
   reload_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lp_reload_o |-> $fell(wd_rst_no));

   // R10
   fall_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_rst_no) |-> wd_fired_o);

   // R7
   fall_leaves_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_rst_no) |-> src_o != 2'd0);
endmodule

// File: tb/tb_wdog_fallback.sv
module tb_wdog_fallback;
   localparam int CLK_PERIOD = 10;
   localparam int PULSE      = 5;
   localparam int STEP       = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       wd_en = 1'b0;
   logic [5:0] span = '0;
   logic [1:0] unit = '0;
   logic       fb_mode = 1'b0;
   logic       lp_reinit = 1'b0;
   logic       wd_rst_no;
   logic [1:0] src;
   logic       fired;
   logic       lp_reload;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;
   bit sparse = 0;
   int phase = 0;

   wdog_fallback #(.IVL_W(6), .UNIT_W(2), .UNIT_STEP_LOG2(STEP), .PULSE_TICKS(PULSE)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wd_en_i(wd_en),
      .span_i(span), .unit_i(unit), .fb_mode_i(fb_mode), .lp_reinit_i(lp_reinit),
      .wd_rst_no(wd_rst_no), .src_o(src), .wd_fired_o(fired), .lp_reload_o(lp_reload)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      phase = (phase + 1) % 3;
      tick <= sparse ? (phase == 0) : 1'b1;
   end

   // behavioural reference model
   int m_cnt, m_limit, m_left, m_src;
   bit m_fired, m_lp;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_limit = 1; m_left = 0; m_src = 0; m_fired = 0; m_lp = 0;
      end else begin
         bit busy, exp;
         int nlim;
         busy = (m_left > 0);
         exp  = wd_en && !busy && tick && (m_cnt == m_limit - 1);
         nlim = ((span == 0) ? 1 : int'(span)) << (int'(unit) * STEP);
         if (exp) m_left = PULSE;
         else if (busy && tick) m_left = m_left - 1;
         if (!wd_en || busy || exp) m_cnt = 0;
         else if (tick) m_cnt = m_cnt + 1;
         if (!wd_en) m_src = 0;
         else if (exp) m_src = (m_src == 0) ? (fb_mode ? 1 : 2) : 2;
         m_fired = m_fired | exp;
         m_lp = exp & lp_reinit;
         if (!wd_en) m_limit = nlim;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 rst pulse vs model", int'(!wd_rst_no), int'(m_left > 0));
         chk("R7 src vs model", int'(src), m_src);
         chk("R10 status vs model", int'(fired), int'(m_fired));
         chk("R11 reload vs model", int'(lp_reload), int'(m_lp));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic time_to_low(output int edges);
      edges = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         edges++;
         if (!wd_rst_no) break;
      end
   endtask

   task automatic low_width(output int w);
      w = 1;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (!wd_rst_no) w++;
         else break;
      end
   endtask

   initial begin
      int e, w;
      bit seen_low;
      step(3);
      // R1 reset state (outputs hold their reset values while rst_n is low)
      chk("R1 rst_n out", int'(wd_rst_no), 1);
      chk("R1 src", int'(src), 0);
      chk("R1 status", int'(fired), 0);
      chk("R1 reload", int'(lp_reload), 0);
      rst_n = 1'b1;
      step(2);

      // R2, R7, R10, R11, R4: span 3 unit 1 -> 6 ticks
      span = 6'd3; unit = 2'd1; fb_mode = 1; lp_reinit = 1;
      step(1);
      wd_en = 1;
      time_to_low(e);
      chk("R2 span length", e, 6);
      chk("R7 first stage fall-back", int'(src), 1);
      chk("R10 status set", int'(fired), 1);
      chk("R11 reload strobe", int'(lp_reload), 1);
      low_width(w);
      chk("R4 pulse width", w, PULSE);

      // R8 second and third timeouts
      time_to_low(e);
      chk("R4 recount after pulse", e, 6);
      chk("R8 second stage jumper", int'(src), 2);
      low_width(w);
      time_to_low(e);
      chk("R8 stays jumper", int'(src), 2);
      low_width(w);
      wd_en = 0;
      step(1);
      chk("R9 disarm clears src", int'(src), 0);
      chk("R10 status sticky", int'(fired), 1);

      // R3 zero span, unit 2 -> 4 ticks; R7 jumper first stage; R11 gated
      span = 0; unit = 2'd2; fb_mode = 0; lp_reinit = 0;
      step(2);
      wd_en = 1;
      time_to_low(e);
      chk("R3 zero span", e, 4);
      chk("R7 first stage jumper", int'(src), 2);
      chk("R11 reload gated", int'(lp_reload), 0);
      low_width(w);
      wd_en = 0;
      step(2);

      // R6 config changed while armed ignored; R9 fresh first stage
      span = 6'd3; unit = 2'd0; fb_mode = 1;
      step(1);
      wd_en = 1;
      step(1);
      span = 6'd63; unit = 2'd3;
      time_to_low(e);
      chk("R6 armed change ignored", e + 1, 3);
      chk("R9 fresh first stage", int'(src), 1);
      low_width(w);
      wd_en = 0;
      step(2);

      // R5 early disarm
      span = 6'd10; unit = 2'd0;
      step(1);
      wd_en = 1;
      step(5);
      wd_en = 0;
      seen_low = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (!wd_rst_no) seen_low = 1;
      end
      chk("R5 no pulse after disarm", int'(seen_low), 0);
      wd_en = 1;
      time_to_low(e);
      chk("R5 full span after rearm", e, 10);
      low_width(w);
      wd_en = 0;
      step(2);

      // mixed patterns with sparse ticks, model-compared every clock
      sparse = 1;
      for (int k = 0; k < 24; k++) begin
         span = 6'(k % 5);
         unit = 2'((k / 5) % 4);
         fb_mode = k[0];
         lp_reinit = k[1];
         wd_en = 1;
         step((k * 7) % 60 + 5);
         span = 6'(k + 9);
         step((k * 3) % 40 + 3);
         wd_en = 0;
         step(3);
      end
      step(5);
      finish_run();
   end
endmodule